// File: doc/BRIEF.md
# Programmable Pseudorandom and Repeating Bit Pattern Source

This block is the transmit half of a bit error rate tester. On each enabled rising edge of the transmit clock it shifts out one NRZ bit. The bit comes either from a shift register with two XOR feedback taps, giving a pseudorandom sequence of up to 32 stages, or from a user word of 1 to 32 bits that recirculates without end. A length field sets the last stage used, which is also the fixed feedback tap. A second field places the other feedback tap.

A load strobe copies a 32-bit seed word into the register and restarts the pattern. A hold input freezes every transmit register, which suits a gapped clock. The output can be inverted. An optional suppression rule keeps zero runs at no more than 14 bits. Errors can be injected at decade rates from 10^-1 to 10^-7, or one bit at a time from a strobe, so that a link and its monitors can be stressed.

Top module: `prbs_pattern_gen`

## Requirements
- R1: While and after asynchronous reset, with every control input low, `data_o` is 0.
- R2: Let the first bit be the bit that `data_o` shows after the third non-held rising clock edge that follows a rise of `load_pin_i | load_bit_i`. That first bit is bit `len_i` of the seed; either strobe input alone starts the load.
- R3: With `prbs_mode_i` = 0, the output is seed bits `len_i` down to 0, most significant first, and repeats with period `len_i`+1. For example, length 7 with seed 0xFFFFFF01 gives one 1 in every 8 bits.
- R4: With `prbs_mode_i` = 1, the register shifts toward higher stages and takes the feedback bit into stage 0. The output is stage `len_i`. The feedback bit is stage `len_i` XOR stage `tap_i`. An all-ones seed with length 6 and tap 5 gives a period of 127.
- R5: While `hold_i` is high, `data_o` keeps its value and nothing advances: the pattern, the error counter, the zero-run count and the strobe edge detectors. Output resumes where it stopped.
- R6: `inv_en_i` = 1 inverts every output bit.
- R7: With `zsup_en_i` = 1, a pattern bit of 0 that follows 14 consecutive 0s is forced to 1. The run is counted on the stream before inversion and error injection. The forced 1 does not enter the shift register.
- R8: A nonzero `err_rate_i` = k inverts output bit number m*10^k for every m >= 1, with bits counted from the first bit after a load. Code 0 inserts no errors. The count advances only on non-held edges.
- R9: A rise of `single_err_i` inverts exactly the output bit of the next non-held edge. Holding the input high inserts nothing more until it falls and rises again.
- R10: A new load restarts both the pattern and the error-rate count from the new seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Transmit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| len_i | input | 5 | Pattern length minus one (fixed tap stage) |
| tap_i | input | 5 | Stage of the programmable feedback tap |
| prbs_mode_i | input | 1 | 1 = pseudorandom, 0 = repeating word |
| seed_i | input | 32 | Word copied into the register on load |
| load_pin_i | input | 1 | Load strobe, pin form |
| load_bit_i | input | 1 | Load strobe, control-bit form |
| hold_i | input | 1 | Freeze all transmit state and output |
| zsup_en_i | input | 1 | Enable 14-zero run suppression |
| inv_en_i | input | 1 | Invert output stream |
| err_rate_i | input | 3 | Automatic error rate code, 0 = off, k = 10^-k |
| single_err_i | input | 1 | Rise inserts a single bit error |
| data_o | output | 1 | Serial NRZ output |

## Verification
The bench builds the block with its defaults: a 32-stage register and seven decade stages. The full register width lets a 32-bit repeating word with a single 1 run long enough to need two forced ones from zero suppression. The decade chain is checked at codes 1, 2 and 3, whose periods of 10, 100 and 1000 bits fit easily in a run, so the carry between decade stages is exercised twice. A maximal-length 127-bit pseudorandom run, with a hold and an inversion in the middle, is compared bit for bit with an independent model.

// File: rtl/pg_pkg.sv
package pg_pkg;
  typedef enum logic {
    PAT_REPEAT = 1'b0,
    PAT_PRBS   = 1'b1
  } pat_mode_e;

  localparam int unsigned ZERO_RUN_MAX = 14;
endpackage

// File: rtl/pg_shift_reg.sv
module pg_shift_reg #(
  parameter int WIDTH = 32,
  localparam int LEN_W = $clog2(WIDTH)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                load_i,
  input  logic [WIDTH-1:0]    seed_i,
  input  logic [LEN_W-1:0]    len_i,
  input  logic [LEN_W-1:0]    tap_i,
  input  pg_pkg::pat_mode_e   mode_i,
  output logic                msb_o
);
  logic [WIDTH-1:0] sr_q;
  logic             fb;

  assign msb_o = sr_q[len_i];
  assign fb    = (mode_i == pg_pkg::PAT_PRBS) ? (sr_q[len_i] ^ sr_q[tap_i]) : sr_q[len_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         sr_q <= '0;
    else if (en_i) begin
      if (load_i)        sr_q <= seed_i;
      else               sr_q <= {sr_q[WIDTH-2:0], fb};
    end
  end

  a_r2_load_copies_seed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && load_i) |=> (sr_q == $past(seed_i)));

  a_r5_frozen_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(sr_q));
endmodule

// File: rtl/pg_decade_err.sv
module pg_decade_err #(
  parameter int DECADES = 7,
  localparam int RATE_W = $clog2(DECADES + 1),
  localparam int SEL_N  = 1 << RATE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              step_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              err_o
);
  logic [DECADES-1:0] wrap;
  logic [SEL_N-1:0]   sel_v;

  for (genvar j = 0; j < DECADES; j++) begin : g_dig
    logic [3:0] dig_q;
    logic       carry_in;
    if (j == 0) begin : g_first
      assign carry_in = 1'b1;
    end else begin : g_next
      assign carry_in = wrap[j-1];
    end
    assign wrap[j] = carry_in && (dig_q == 4'd9);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        dig_q <= '0;
      else if (clr_i)     dig_q <= '0;
      else if (step_i) begin
        if (wrap[j])      dig_q <= '0;
        else if (carry_in) dig_q <= dig_q + 4'd1;
      end
    end
  end

  // bit 0 is code 0 (off); code k selects completion of the k lowest decades
  assign sel_v = SEL_N'({wrap, 1'b0});
  assign err_o = step_i && sel_v[rate_i];

  a_r8_off_means_none: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (rate_i != '0));

  a_r10_clear_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !err_o);
endmodule

// File: rtl/prbs_pattern_gen.sv
module prbs_pattern_gen #(
  parameter int WIDTH   = 32,
  parameter int DECADES = 7,
  localparam int LEN_W  = $clog2(WIDTH),
  localparam int RATE_W = $clog2(DECADES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [LEN_W-1:0]  tap_i,
  input  logic              prbs_mode_i,
  input  logic [WIDTH-1:0]  seed_i,
  input  logic              load_pin_i,
  input  logic              load_bit_i,
  input  logic              hold_i,
  input  logic              zsup_en_i,
  input  logic              inv_en_i,
  input  logic [RATE_W-1:0] err_rate_i,
  input  logic              single_err_i,
  output logic              data_o
);
  localparam int ZW = $clog2(pg_pkg::ZERO_RUN_MAX + 1);
  localparam logic [ZW-1:0] ZMAX = ZW'(pg_pkg::ZERO_RUN_MAX);

  logic          run;
  logic          ld_q, ld_qq, ld_rise;
  logic          se_q, se_rise;
  logic          raw_bit, force_one, sup_bit, dec_err;
  logic [ZW-1:0] zc_q;
  pg_pkg::pat_mode_e mode;

  assign run     = !hold_i;
  assign mode    = pg_pkg::pat_mode_e'(prbs_mode_i);
  assign ld_rise = ld_q && !ld_qq;
  assign se_rise = single_err_i && !se_q;

  pg_shift_reg #(.WIDTH(WIDTH)) u_sr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (run),
    .load_i (ld_rise),
    .seed_i (seed_i),
    .len_i  (len_i),
    .tap_i  (tap_i),
    .mode_i (mode),
    .msb_o  (raw_bit)
  );

  pg_decade_err #(.DECADES(DECADES)) u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (run && ld_rise),
    .step_i (run && !ld_rise),
    .rate_i (err_rate_i),
    .err_o  (dec_err)
  );

  assign force_one = zsup_en_i && !raw_bit && (zc_q == ZMAX);
  assign sup_bit   = raw_bit || force_one;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_q   <= 1'b0;
      ld_qq  <= 1'b0;
      se_q   <= 1'b0;
      zc_q   <= '0;
      data_o <= 1'b0;
    end else if (run) begin
      ld_q   <= load_pin_i || load_bit_i;
      ld_qq  <= ld_q;
      se_q   <= single_err_i;
      data_o <= sup_bit ^ inv_en_i ^ dec_err ^ se_rise;
      if (ld_rise || sup_bit) zc_q <= '0;
      else if (zc_q != ZMAX)  zc_q <= zc_q + 1'b1;
    end
  end

  a_r5_hold_keeps_output: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> $stable(data_o));

  a_r7_zero_run_forced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && zsup_en_i && (zc_q == ZMAX) && !ld_rise && !dec_err && !se_rise)
      |=> (data_o == !$past(inv_en_i)));

  a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && $past(run) && single_err_i && $past(single_err_i)) |-> !se_rise);
endmodule

// File: tb/prbs_pattern_gen_test.sv
module prbs_pattern_gen_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  len_i = '0, tap_i = '0;
  logic        prbs_mode_i = 1'b0;
  logic [31:0] seed_i = '0;
  logic        load_pin_i = 1'b0, load_bit_i = 1'b0, hold_i = 1'b0;
  logic        zsup_en_i = 1'b0, inv_en_i = 1'b0, single_err_i = 1'b0;
  logic [2:0]  err_rate_i = '0;
  logic        data_o;

  always #4 clk = ~clk;

  prbs_pattern_gen uut (
    .clk_i(clk), .rst_ni(rst_ni), .len_i(len_i), .tap_i(tap_i),
    .prbs_mode_i(prbs_mode_i), .seed_i(seed_i), .load_pin_i(load_pin_i),
    .load_bit_i(load_bit_i), .hold_i(hold_i), .zsup_en_i(zsup_en_i),
    .inv_en_i(inv_en_i), .err_rate_i(err_rate_i), .single_err_i(single_err_i),
    .data_o(data_o)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  bit    exp_q[$];
  string tag_q[$];

  // reference model state
  logic [31:0] m_sr;
  int          m_zc, m_nbit;
  bit          m_se, last_out;

  function automatic int p10(int k);
    int v = 1;
    for (int i = 0; i < k; i++) v = v * 10;
    return v;
  endfunction

  task automatic check(bit act, bit exp, string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: data_o=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // monitor: pops one expected bit per edge it was pushed for
  initial forever begin
    @(posedge clk); #2;
    if (exp_q.size() > 0) check(data_o, exp_q.pop_front(), tag_q.pop_front());
  end

  task automatic load(logic [31:0] seed, bit via_pin);
    seed_i = seed;
    if (via_pin) load_pin_i = 1'b1; else load_bit_i = 1'b1;
    @(negedge clk);
    load_pin_i = 1'b0; load_bit_i = 1'b0;
    @(negedge clk);
    m_sr = seed; m_zc = 0; m_nbit = 0; m_se = single_err_i;
  endtask

  task automatic step(bit hold, bit se, string tag);
    bit raw, b, derr, serr, fb;
    hold_i = hold; single_err_i = se;
    if (hold) begin
      exp_q.push_back(last_out); tag_q.push_back(tag);
    end else begin
      raw  = m_sr[len_i];
      b    = raw | (zsup_en_i && !raw && m_zc == 14);
      m_nbit++;
      derr = (err_rate_i != 0) && (m_nbit % p10(int'(err_rate_i)) == 0);
      serr = se && !m_se;
      last_out = b ^ inv_en_i ^ derr ^ serr;
      exp_q.push_back(last_out); tag_q.push_back(tag);
      m_zc = b ? 0 : (m_zc == 14 ? 14 : m_zc + 1);
      fb   = prbs_mode_i ? (m_sr[len_i] ^ m_sr[tap_i]) : m_sr[len_i];
      m_sr = {m_sr[30:0], fb};
      m_se = se;
    end
    @(negedge clk);
  endtask

  task automatic run_bits(int n, string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    bit ones[$];
    int n1;
    #3; check(data_o, 1'b0, "R1 in reset");
    @(negedge clk); @(negedge clk); rst_ni = 1'b1;
    for (int i = 0; i < 3; i++) @(negedge clk);
    check(data_o, 1'b0, "R1 after reset");

    // R2/R3: repeating word, one 1 in 8, load by pin
    prbs_mode_i = 0; len_i = 5'd7;
    load(32'hFFFF_FF01, 1'b1);
    step(1'b0, 1'b0, "R2 first bit is seed[len] (pin load)");
    run_bits(23, "R3 period len+1");
    wait (exp_q.size() == 0); @(negedge clk);

    // R2 via control bit, R3 double alternating, period 4
    len_i = 5'd3;
    load(32'hFFFF_FFFC, 1'b0);
    step(1'b0, 1'b0, "R2 first bit is seed[len] (bit load)");
    run_bits(15, "R3 period 4");

    // R3: length 31 full word
    len_i = 5'd31;
    load(32'hA5C3_0F96, 1'b1);
    run_bits(70, "R3 full 32-bit word");

    // R4: pseudorandom, 127-bit period; R5 hold and R6 inversion inside
    prbs_mode_i = 1; len_i = 5'd6; tap_i = 5'd5;
    load(32'hFFFF_FFFF, 1'b1);
    run_bits(40, "R4 prbs sequence");
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, "R5 hold keeps output");
    run_bits(30, "R5 resume after hold");
    inv_en_i = 1'b1;
    run_bits(20, "R6 inverted stream");
    inv_en_i = 1'b0;
    run_bits(200, "R4 prbs sequence");
    wait (exp_q.size() == 0); @(negedge clk);

    // R4: period 127 observed directly at the port
    load(32'hFFFF_FFFF, 1'b0);
    ones.delete();
    for (int i = 0; i < 254; i++) begin
      @(posedge clk); #2; ones.push_back(data_o);
    end
    n1 = 0;
    for (int i = 0; i < 127; i++) if (ones[i] != ones[i+127]) n1++;
    check(n1 == 0, 1'b1, "R4 period 127");
    n1 = 0;
    for (int i = 0; i < 127; i++) n1 += ones[i];
    check(n1 == 64, 1'b1, "R4 64 ones per period");
    @(negedge clk);

    // R7: zero suppression on long zero run
    prbs_mode_i = 0; len_i = 5'd31; zsup_en_i = 1'b1;
    load(32'h0000_0001, 1'b1);
    run_bits(100, "R7 zero suppression");
    inv_en_i = 1'b1;
    run_bits(40, "R7 suppression before inversion");
    inv_en_i = 1'b0; zsup_en_i = 1'b0;
    run_bits(40, "R7 off allows long run");

    // R8: decade error rates on all-ones stream
    len_i = 5'd0;
    err_rate_i = 3'd1;
    load(32'hFFFF_FFFF, 1'b1);
    run_bits(45, "R8 rate code 1");
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, "R8 hold does not count");
    run_bits(20, "R8 rate code 1 after hold");
    err_rate_i = 3'd2;
    load(32'hFFFF_FFFF, 1'b0);
    run_bits(210, "R8 rate code 2");
    err_rate_i = 3'd3;
    load(32'hFFFF_FFFF, 1'b1);
    run_bits(1005, "R8 rate code 3");
    err_rate_i = 3'd0;
    run_bits(30, "R8 code 0 inserts none");

    // R10: reload mid-count restarts the rate counter
    err_rate_i = 3'd1;
    load(32'hFFFF_FFFF, 1'b1);
    run_bits(7, "R10 before reload");
    load(32'hFFFF_FFFF, 1'b0);
    run_bits(25, "R10 restarted count");
    err_rate_i = 3'd0;

    // R9: single error, level held, rise during hold
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, "R9 idle");
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1, "R9 one bit per rise");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, "R9 after fall");
    step(1'b1, 1'b1, "R9 rise while held");
    step(1'b1, 1'b1, "R9 rise while held");
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, "R9 applied after hold");
    step(1'b0, 1'b0, "R9 idle");
    wait (exp_q.size() == 0); @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule